// File: doc/BRIEF.md
# Recently-Read Triggered Remap Controller

This controller decides when the blocks of a memory chunk are shuffled to new addresses, and which blocks take part. It holds one recently-read (RR) flag for every block of the chunk. A fill from memory sets the flag. When the cache evicts a block whose RR flag is clear, the eviction is accepted at once and nothing else happens. When the evicted block has its RR flag set, the controller stalls the eviction and builds a window of pages. The window starts at the evicted block's page and widens one neighbouring page per cycle until it holds at least `TARGET` RR blocks.

If the whole chunk holds too few RR blocks, the controller issues read requests for the shortfall. It then streams out the list of selected blocks, which are exactly `TARGET` RR blocks of the window. It pulses a permute strobe and releases the eviction. The remapping arithmetic is done downstream.

Eviction, read requests and the selected list each use valid/ready. The eviction requester must hold `evict_valid` and its page and block stable until `evict_ready` is seen high. The read-request and selection streams hold valid and payload stable while ready is low. Either consumer may stall for any number of cycles. The fill pins are plain control inputs.

Top module: `rrperm_ctrl`

## Requirements
- R1: While the controller is idle, an eviction of a block whose RR flag is clear is accepted in the same cycle (`evict_ready` high). It produces no permute strobe, no read request and no selected block.
- R2: A fill pulse (`fill_en`) in the idle state sets the RR flag of block {`fill_page`,`fill_blk`}. A fill pulse while an eviction is being processed is ignored.
- R3: An eviction of a block whose RR flag is set is held with `evict_ready` low until processing ends. It is then accepted in the one cycle in which `perm_strobe` pulses, exactly once per such eviction.
- R4: The window starts as the evicted page. While it holds fewer than `TARGET` RR blocks, it grows by one page per step. Steps alternate between the next higher page and the next lower page, starting with the higher one. When one side is at the chunk edge (page 0 or page `NUM_PAGES-1`), the other side is taken. Growth stops when the count is reached or the whole chunk is covered.
- R5: If the whole chunk holds fewer than `TARGET` RR blocks, exactly the shortfall is requested on the read stream. The requests go to blocks whose RR flag is clear, in ascending order of the index {page,block}. Each accepted request sets that block's RR flag.
- R6: The selected list holds exactly `TARGET` entries. They are the first RR blocks of the window in ascending page order, and in ascending block order within a page. `sel_last` marks the final entry.
- R7: Every emitted block and the evicted block have their RR flags cleared, so a later eviction of any of them is accepted immediately.
- R8: On the read and selection streams, valid stays high and the payload stays unchanged while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | A block was filled from memory |
| fill_page | input | PW | Page of the filled block |
| fill_blk | input | BW | Block index of the filled block |
| evict_valid | input | 1 | Eviction request |
| evict_ready | output | 1 | Eviction accepted |
| evict_page | input | PW | Page of the evicted block |
| evict_blk | input | BW | Block index of the evicted block |
| rd_valid | output | 1 | Read request for a shortfall block |
| rd_ready | input | 1 | Read request taken |
| rd_page | output | PW | Page to read |
| rd_blk | output | BW | Block to read |
| sel_valid | output | 1 | Selected-block entry valid |
| sel_ready | input | 1 | Selected-block entry taken |
| sel_page | output | PW | Page of the selected block |
| sel_blk | output | BW | Block index of the selected block |
| sel_last | output | 1 | Final entry of the list |
| perm_strobe | output | 1 | One-cycle pulse: a permutation is to run over the list |

## Verification
The assertions take several things for granted about the inputs:
- An eviction request stays asserted with a stable address until it is accepted.
- `NUM_PAGES` and `BLOCKS_PER_PAGE` are powers of two.
- `TARGET` does not exceed the number of blocks in the chunk, so the shortfall reads always find enough blocks with a clear flag.

The stimulus holds every eviction until `evict_ready` is seen. It drives fills only in idle, except for one deliberate pulse during a stall that checks R2. It throttles both ready inputs with different periodic patterns, so that the stall paths of R8 are exercised.

// File: rtl/rrperm_pkg.sv
package rrperm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_SEARCH,
    ST_FILL,
    ST_PERMUTE,
    ST_DONE
  } ctrl_state_t;
endpackage

// File: rtl/rrperm_bitmap.sv
// One RR flag per block of the chunk, with one set port and one clear port.
module rrperm_bitmap #(
  parameter int NUM_PAGES       = 8,
  parameter int BLOCKS_PER_PAGE = 8,
  localparam int NB = NUM_PAGES * BLOCKS_PER_PAGE,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [NB-1:0] bits_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_o <= '0;
    end else begin
      if (set_en) bits_o[set_idx] <= 1'b1;
      if (clr_en) bits_o[clr_idx] <= 1'b0;
    end
  end

  // R7: a flag is never set and cleared in the same cycle
  a_r7_no_set_clear_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en && set_idx == clr_idx));
endmodule

// File: rtl/rrperm_pagecount.sv
// Number of RR flags set in each page.
module rrperm_pagecount #(
  parameter int NUM_PAGES       = 8,
  parameter int BLOCKS_PER_PAGE = 8,
  localparam int NB  = NUM_PAGES * BLOCKS_PER_PAGE,
  localparam int PCW = $clog2(BLOCKS_PER_PAGE + 1)
) (
  input  logic [NB-1:0]  bits_i,
  output logic [PCW-1:0] cnt_o [NUM_PAGES]
);
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic [PCW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < BLOCKS_PER_PAGE; j++)
        acc = acc + PCW'(bits_i[g*BLOCKS_PER_PAGE + j]);
    end
    assign cnt_o[g] = acc;
  end
endmodule

// File: rtl/rrperm_ctrl.sv
module rrperm_ctrl
  import rrperm_pkg::*;
#(
  parameter int NUM_PAGES       = 8,
  parameter int BLOCKS_PER_PAGE = 8,
  parameter int TARGET          = 8,
  localparam int PW  = $clog2(NUM_PAGES),
  localparam int BW  = $clog2(BLOCKS_PER_PAGE),
  localparam int NB  = NUM_PAGES * BLOCKS_PER_PAGE,
  localparam int IW  = PW + BW,
  localparam int CW  = $clog2(NB + 1),
  localparam int PCW = $clog2(BLOCKS_PER_PAGE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [PW-1:0] fill_page,
  input  logic [BW-1:0] fill_blk,
  input  logic          evict_valid,
  output logic          evict_ready,
  input  logic [PW-1:0] evict_page,
  input  logic [BW-1:0] evict_blk,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [PW-1:0] rd_page,
  output logic [BW-1:0] rd_blk,
  output logic          sel_valid,
  input  logic          sel_ready,
  output logic [PW-1:0] sel_page,
  output logic [BW-1:0] sel_blk,
  output logic          sel_last,
  output logic          perm_strobe
);
  localparam logic [CW-1:0] TGT = CW'(TARGET);

  ctrl_state_t   state;
  logic [PW-1:0] ev_page, lo, hi;
  logic [BW-1:0] ev_blk;
  logic [CW-1:0] total, emitted;
  logic          dir_up;
  logic [IW-1:0] ptr;

  logic [NB-1:0]  rr;
  logic [PCW-1:0] pcnt [NUM_PAGES];
  logic           set_en, clr_en;
  logic [IW-1:0]  set_idx, clr_idx;

  rrperm_bitmap #(.NUM_PAGES(NUM_PAGES), .BLOCKS_PER_PAGE(BLOCKS_PER_PAGE)) u_bitmap (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_idx(set_idx),
    .clr_en(clr_en), .clr_idx(clr_idx), .bits_o(rr));

  rrperm_pagecount #(.NUM_PAGES(NUM_PAGES), .BLOCKS_PER_PAGE(BLOCKS_PER_PAGE)) u_count (
    .bits_i(rr), .cnt_o(pcnt));

  logic ev_rr, ptr_bit, can_up, can_dn, take_up, rd_fire, sel_fire;
  logic [PW-1:0] hi_nxt, lo_nxt;

  assign ev_rr   = rr[{evict_page, evict_blk}];
  assign ptr_bit = rr[ptr];
  assign can_up  = hi != PW'(NUM_PAGES - 1);
  assign can_dn  = lo != '0;
  assign take_up = can_up && (dir_up || !can_dn);
  assign hi_nxt  = hi + PW'(1);
  assign lo_nxt  = lo - PW'(1);

  assign rd_valid    = (state == ST_FILL) && (total < TGT) && !ptr_bit;
  assign sel_valid   = (state == ST_PERMUTE) && (emitted < TGT) && ptr_bit;
  assign rd_fire     = rd_valid && rd_ready;
  assign sel_fire    = sel_valid && sel_ready;
  assign rd_page     = ptr[IW-1:BW];
  assign rd_blk      = ptr[BW-1:0];
  assign sel_page    = ptr[IW-1:BW];
  assign sel_blk     = ptr[BW-1:0];
  assign sel_last    = sel_valid && (emitted == TGT - CW'(1));
  assign perm_strobe = (state == ST_DONE);
  assign evict_ready = ((state == ST_IDLE) && !ev_rr) || (state == ST_DONE);

  assign set_en  = ((state == ST_IDLE) && fill_en) || rd_fire;
  assign set_idx = (state == ST_FILL) ? ptr : {fill_page, fill_blk};
  assign clr_en  = sel_fire || (state == ST_DONE);
  assign clr_idx = (state == ST_DONE) ? {ev_page, ev_blk} : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ev_page <= '0;
      ev_blk  <= '0;
      lo      <= '0;
      hi      <= '0;
      total   <= '0;
      emitted <= '0;
      dir_up  <= 1'b1;
      ptr     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (evict_valid && ev_rr) begin
          ev_page <= evict_page;
          ev_blk  <= evict_blk;
          lo      <= evict_page;
          hi      <= evict_page;
          state   <= ST_COUNT;
        end
        ST_COUNT: begin
          total  <= CW'(pcnt[ev_page]);
          dir_up <= 1'b1;
          state  <= ST_SEARCH;
        end
        ST_SEARCH: begin
          if (total >= TGT) begin
            ptr     <= {lo, BW'(0)};
            emitted <= '0;
            state   <= ST_PERMUTE;
          end else if (take_up) begin
            hi     <= hi_nxt;
            total  <= total + CW'(pcnt[hi_nxt]);
            dir_up <= 1'b0;
          end else if (can_dn) begin
            lo     <= lo_nxt;
            total  <= total + CW'(pcnt[lo_nxt]);
            dir_up <= 1'b1;
          end else begin
            ptr   <= {lo, BW'(0)};
            state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (total >= TGT) begin
            ptr     <= {lo, BW'(0)};
            emitted <= '0;
            state   <= ST_PERMUTE;
          end else if (rd_fire) begin
            total <= total + CW'(1);
            ptr   <= ptr + IW'(1);
          end else if (ptr_bit) begin
            ptr <= ptr + IW'(1);
          end
        end
        ST_PERMUTE: begin
          if (emitted >= TGT) begin
            state <= ST_DONE;
          end else if (sel_fire) begin
            emitted <= emitted + CW'(1);
            ptr     <= ptr + IW'(1);
          end else if (!ptr_bit) begin
            ptr <= ptr + IW'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a recently-read eviction is never accepted mid-processing
  a_r3_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_COUNT, ST_SEARCH, ST_FILL, ST_PERMUTE}) |-> !evict_ready);
  // R3: the strobe is a single-cycle pulse
  a_r3_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    perm_strobe |=> !perm_strobe);
  // R3: input rule, the requester holds its eviction until accepted
  a_r3_evict_held: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && !evict_ready |=> evict_valid);
  // R4: the window always contains the evicted page
  a_r4_window_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH) |-> (lo <= ev_page && ev_page <= hi));
  // R6: never more entries than the target
  a_r6_emit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    emitted <= TGT);
  // R8: stream payloads are held under back-pressure
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && !sel_ready |=> sel_valid && $stable(sel_page) && $stable(sel_blk));
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_page) && $stable(rd_blk));
endmodule

// File: tb/rrperm_ctrl_test.sv
module rrperm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int BP = 8;
  localparam int T  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_en = 1'b0, evict_valid = 1'b0, rd_ready = 1'b0, sel_ready = 1'b0;
  logic [2:0] fill_page = '0, fill_blk = '0, evict_page = '0, evict_blk = '0;
  logic evict_ready, rd_valid, sel_valid, sel_last, perm_strobe;
  logic [2:0] rd_page, rd_blk, sel_page, sel_blk;

  rrperm_ctrl #(.NUM_PAGES(NP), .BLOCKS_PER_PAGE(BP), .TARGET(T)) uut (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_page(fill_page), .fill_blk(fill_blk),
    .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_page(evict_page),
    .evict_blk(evict_blk), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_page(rd_page),
    .rd_blk(rd_blk), .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_page(sel_page),
    .sel_blk(sel_blk), .sel_last(sel_last), .perm_strobe(perm_strobe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, strobes = 0;
  bit mdl [NP][BP];
  int selq[$];
  int rdq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int page_cnt(input int p);
    int c = 0;
    for (int b = 0; b < BP; b++) c += int'(mdl[p][b]);
    return c;
  endfunction

  // Behavioural expectation for an RR eviction (R4, R5, R6, R7)
  task automatic plan(input int p, input int b);
    int lo = p, hi = p, tot = page_cnt(p), e = 0;
    bit up = 1;
    while (tot < T) begin
      bit cu = hi < NP - 1;
      bit cd = lo > 0;
      if (cu && (up || !cd)) begin hi++; tot += page_cnt(hi); up = 0; end
      else if (cd) begin lo--; tot += page_cnt(lo); up = 1; end
      else break;
    end
    for (int pg = lo; pg <= hi; pg++)
      for (int bl = 0; bl < BP; bl++)
        if (!mdl[pg][bl] && tot < T) begin rdq.push_back(pg*BP + bl); mdl[pg][bl] = 1; tot++; end
    for (int pg = lo; pg <= hi; pg++)
      for (int bl = 0; bl < BP; bl++)
        if (mdl[pg][bl] && e < T) begin selq.push_back(pg*BP + bl); mdl[pg][bl] = 0; e++; end
    mdl[p][b] = 0;
  endtask

  // Per-clock comparison of stream outputs with the expected queues
  always @(negedge clk) if (rst_n) begin
    cyc++;
    sel_ready <= (cyc % 3) != 1;
    rd_ready  <= (cyc % 4) != 2;
    #1;
    if (sel_valid && sel_ready) begin
      if (selq.size() == 0) check(0, "R6 unexpected selection", sel_page*BP + sel_blk, -1);
      else begin
        check(sel_page*BP + sel_blk == selq[0], "R6 selection order", sel_page*BP + sel_blk, selq[0]);
        check(sel_last == (selq.size() == 1), "R6 sel_last", sel_last, selq.size() == 1);
        void'(selq.pop_front());
      end
    end
    if (rd_valid && rd_ready) begin
      if (rdq.size() == 0) check(0, "R5 unexpected read", rd_page*BP + rd_blk, -1);
      else begin
        check(rd_page*BP + rd_blk == rdq[0], "R5 read order", rd_page*BP + rd_blk, rdq[0]);
        void'(rdq.pop_front());
      end
    end
    if (perm_strobe) strobes++;
  end

  task automatic fill(input int p, input int b);
    @(negedge clk); #2;
    fill_en = 1; fill_page = 3'(p); fill_blk = 3'(b);
    mdl[p][b] = 1;
    @(negedge clk); #2;
    fill_en = 0;
  endtask

  task automatic evict(input int p, input int b, input bit inject, input int fp, input int fb);
    bit rr = mdl[p][b];
    int k = 0;
    if (rr) plan(p, b);
    strobes = 0;
    @(negedge clk); #2;
    evict_valid = 1; evict_page = 3'(p); evict_blk = 3'(b);
    @(negedge clk); #2;
    if (rr) check(!evict_ready, "R3 stall on RR eviction", evict_ready, 0);
    else    check(evict_ready,  "R1 immediate accept", evict_ready, 1);
    while (!evict_ready) begin
      @(negedge clk); #2;
      k++;
      fill_en = 0;
      if (inject && k == 2) begin fill_en = 1; fill_page = 3'(fp); fill_blk = 3'(fb); end
      if (k > 2000) break;
    end
    @(posedge clk); #1;
    evict_valid = 0; fill_en = 0;
    @(negedge clk); #3;
    check(strobes == int'(rr), rr ? "R3 one strobe" : "R1 no strobe", strobes, int'(rr));
    check(selq.size() == 0, "R6 list complete", selq.size(), 0);
    check(rdq.size() == 0, "R5 reads complete", rdq.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(!sel_valid && !rd_valid && !perm_strobe, "R1 reset outputs idle", sel_valid | rd_valid | perm_strobe, 0);
    check(evict_ready, "R1 reset flags clear", evict_ready, 1);
    evict(0, 0, 0, 0, 0);                           // R1 non-RR eviction
    for (int b = 0; b < BP; b++) fill(3, b);        // R2 fills
    evict(3, 5, 0, 0, 0);                           // R6 single page suffices
    evict(3, 5, 0, 0, 0);                           // R7 flag cleared
    fill(2, 1); fill(2, 4); fill(2, 6); fill(3, 0); fill(3, 7);
    fill(4, 0); fill(4, 2); fill(4, 3); fill(4, 5);
    evict(3, 7, 0, 0, 0);                           // R4 up then down
    evict(2, 1, 0, 0, 0);                           // R7 emitted flag cleared
    fill(7, 1); fill(7, 2); fill(6, 0);
    evict(7, 2, 1, 1, 1);                           // R4 top edge, R5 shortfall, R2 ignored fill
    evict(1, 1, 0, 0, 0);                           // R2 busy fill had no effect
    fill(0, 7);
    for (int b = 0; b < BP; b++) fill(1, b);
    evict(0, 7, 0, 0, 0);                           // R4 bottom edge
    evict(1, 7, 0, 0, 0);                           // R6 leftover block still RR
    fill(5, 5);
    evict(5, 4, 0, 0, 0);                           // R1 neighbour of RR block
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule